// File: doc/BRIEF.md
# Slack Buffer Receiver with Stop/Go Flow Control

This block sits at the receive end of a full-duplex link that carries one 9-bit symbol per cycle in each direction. Bit 8 of a symbol is a control flag and bits 7:0 carry the payload. Arriving symbols go into a slack FIFO, and a consumer drains them in arrival order. The block watches the FIFO fill level. It asks the far end to pause by putting a stop symbol on the outgoing channel, and it lets the far end resume with a go symbol. The two thresholds are separated by a hysteresis band. Spare room above the stop threshold absorbs the symbols that are still on the wire when the stop is sent. Spare room below the go threshold keeps the consumer fed while the go symbol travels back.

The same block also gates the local transmitter. A stop symbol received from the far end is taken out of the stream and pauses local data after the byte already accepted. A go symbol received from the far end resumes local data. The FIFO depth is the sum of three parameters: the slack above the stop threshold, the hysteresis band, and the slack below the go threshold. With the defaults of 32, 16 and 32 the depth is 80, the stop threshold is 48 and the go threshold is 32.

Top module: `slack_rx_link`

## Requirements
- R1: After reset the FIFO is empty (`out_valid`=0), `tx_valid`=0, `ovf_err`=0 and the block is in the go state with local sending enabled (`tx_req_ready`=1).
- R2: Data symbols (bit 8 = 0) and control symbols other than stop and go are stored and delivered on `out_sym` in arrival order. A symbol is removed when `out_valid` and `out_ready` are both 1 at a clock edge.
- R3: The stop symbol 9'h1F1 and the go symbol 9'h1F2 arriving on `rx_sym` are never stored. They leave the fill level unchanged.
- R4: When the fill level reaches 48 or more in the go state, a single stop symbol (9'h1F1) appears on `tx_sym` with `tx_valid`=1 in the cycle after the level reaches 48. It is not sent again while the level stays high.
- R5: When the fill level falls to 32 or fewer after a stop was sent, a single go symbol (9'h1F2) appears on `tx_sym` in the cycle after the level reaches 32. No go symbol is sent while the level stays above 32.
- R6: A flow symbol that is due takes the outgoing channel: `tx_req_ready` is 0 in the cycle the decision is pending. Local data accepted with `tx_req_valid` and `tx_req_ready` both 1 appears on `tx_sym` in the next cycle.
- R7: A stop symbol received on `rx_sym` lets the local byte accepted in that same cycle go out. From the next cycle, `tx_req_ready` stays 0 until a go symbol is received.
- R8: A data symbol that arrives while the FIFO holds 80 entries is discarded, and `ovf_err` is set. `ovf_err` stays set until reset.
- R9: The FIFO holds 80 symbols without loss and without raising `ovf_err`.
- R10: `tx_valid` is 0 in any cycle that follows a cycle with no flow symbol due and no local byte accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A symbol is present on rx_sym |
| rx_sym | input | 9 | Incoming symbol; bit 8 is the control flag |
| out_valid | output | 1 | FIFO holds at least one symbol |
| out_sym | output | 9 | Oldest stored symbol |
| out_ready | input | 1 | Consumer takes out_sym this cycle |
| tx_req_valid | input | 1 | Local transmitter has a symbol to send |
| tx_req_sym | input | 9 | Local symbol to send |
| tx_req_ready | output | 1 | Local symbol is accepted this cycle |
| tx_valid | output | 1 | Outgoing channel carries a symbol |
| tx_sym | output | 9 | Outgoing symbol (stop, go or local data) |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The hardest state to reach is a full FIFO with one more data symbol arriving. To get there, the far end has to ignore a stop that was already sent and keep sending until all 32 slack entries are used. The bench plays an ill-behaved far end: it writes 80 data symbols back to back with the consumer stalled, and it sends the stop symbol out without ever reacting to it. It then offers one extra symbol and drains all 80 entries to show that the extra one was dropped. Reaching the go threshold exactly takes a similar count: after the stop, the drain runs one entry at a time, so the go symbol can be checked in the single cycle where it is due.

// File: rtl/slack_pkg.sv
// Shared symbol type and flow-control codes for the slack buffer receiver.
// Assumes a 9-bit symbol with the control flag in bit 8.
package slack_pkg;
    localparam int SYM_W = 9;
    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t STOP_SYM = 9'h1F1;
    localparam sym_t GO_SYM   = 9'h1F2;

    // True for the two symbols that regulate the link instead of carrying data
    function automatic logic is_flow(input sym_t s);
        return (s == STOP_SYM) || (s == GO_SYM);
    endfunction
endpackage

// File: rtl/slack_fifo.sv
// Circular FIFO of any depth (not limited to a power of two) with an
// occupancy count. A write into a full FIFO is ignored, and so is a read
// from an empty one. Read data comes straight from storage.
module slack_fifo #(
    parameter int DEPTH = 80,
    parameter int W     = 9,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_wr, do_rd;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointer advance with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n)               level <= '0;
        else if (do_wr && !do_rd) level <= level + 1'b1;
        else if (do_rd && !do_wr) level <= level - 1'b1;
    end
endmodule

// File: rtl/rx_sorter.sv
// Splits the incoming symbol stream. Stop and go symbols are removed and
// drive the local pause flag; every other symbol is passed on for storage.
// Assumes at most one symbol per cycle.
module rx_sorter
    import slack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  sym_t rx_sym,
    output logic store_en,
    output logic paused
);
    assign store_en = rx_valid && !is_flow(rx_sym);

    // Pause flag follows the last flow symbol seen from the far end
    always_ff @(posedge clk) begin
        if (!rst_n)                             paused <= 1'b0;
        else if (rx_valid && rx_sym == STOP_SYM) paused <= 1'b1;
        else if (rx_valid && rx_sym == GO_SYM)   paused <= 1'b0;
    end
endmodule

// File: rtl/flow_tx.sv
// Outgoing channel driver. A hysteresis state machine on the fill level
// decides when a stop or go is due. A due flow symbol wins the channel;
// otherwise a local symbol is sent unless the far end has paused us.
// Output is registered, so a symbol appears one cycle after its decision.
module flow_tx
    import slack_pkg::*;
#(
    parameter int LVL_W    = 7,
    parameter int STOP_LVL = 48,
    parameter int GO_LVL   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             paused,
    input  logic             req_valid,
    input  sym_t             req_sym,
    output logic             req_ready,
    output logic             tx_valid,
    output sym_t             tx_sym
);
    localparam logic [LVL_W-1:0] HI = LVL_W'(STOP_LVL);
    localparam logic [LVL_W-1:0] LO = LVL_W'(GO_LVL);

    logic stopped;
    logic need_stop, need_go;

    assign need_stop = !stopped && (level >= HI);
    assign need_go   = stopped && (level <= LO);
    assign req_ready = !paused && !need_stop && !need_go;

    // Remember which flow symbol was sent last
    always_ff @(posedge clk) begin
        if (!rst_n)         stopped <= 1'b0;
        else if (need_stop) stopped <= 1'b1;
        else if (need_go)   stopped <= 1'b0;
    end

    // Choose and register the symbol for the outgoing channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_sym   <= '0;
        end else if (need_stop) begin
            tx_valid <= 1'b1;
            tx_sym   <= STOP_SYM;
        end else if (need_go) begin
            tx_valid <= 1'b1;
            tx_sym   <= GO_SYM;
        end else if (req_valid && req_ready) begin
            tx_valid <= 1'b1;
            tx_sym   <= req_sym;
        end else begin
            tx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/slack_rx_link.sv
// Receive side of a byte link with stop/go flow control. Incoming data goes
// to a slack FIFO whose depth is split into slack above the stop level, a
// hysteresis band, and slack below the go level. The block also gates the
// local transmitter on flow symbols from the far end. An overflow drops
// the arriving symbol and sets a sticky error.
module slack_rx_link
    import slack_pkg::*;
#(
    parameter int SLACK_ABOVE = 32,
    parameter int HYST_BAND   = 16,
    parameter int SLACK_BELOW = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [8:0] rx_sym,
    output logic       out_valid,
    output logic [8:0] out_sym,
    input  logic       out_ready,
    input  logic       tx_req_valid,
    input  logic [8:0] tx_req_sym,
    output logic       tx_req_ready,
    output logic       tx_valid,
    output logic [8:0] tx_sym,
    output logic       ovf_err
);
    localparam int DEPTH    = SLACK_ABOVE + HYST_BAND + SLACK_BELOW;
    localparam int STOP_LVL = SLACK_BELOW + HYST_BAND;
    localparam int GO_LVL   = SLACK_BELOW;
    localparam int LVL_W    = $clog2(DEPTH + 1);

    logic             store_en, paused;
    logic             fifo_full, fifo_empty;
    logic [LVL_W-1:0] fill_lvl;

    rx_sorter u_sort (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_sym   (rx_sym),
        .store_en (store_en),
        .paused   (paused)
    );

    slack_fifo #(.DEPTH(DEPTH), .W(SYM_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_data (rx_sym),
        .rd_en   (out_ready),
        .rd_data (out_sym),
        .level   (fill_lvl),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    assign out_valid = !fifo_empty;

    flow_tx #(.LVL_W(LVL_W), .STOP_LVL(STOP_LVL), .GO_LVL(GO_LVL)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fill_lvl),
        .paused    (paused),
        .req_valid (tx_req_valid),
        .req_sym   (tx_req_sym),
        .req_ready (tx_req_ready),
        .tx_valid  (tx_valid),
        .tx_sym    (tx_sym)
    );

    // Sticky record of a symbol lost to a full FIFO
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_err <= 1'b0;
        else if (store_en && fifo_full) ovf_err <= 1'b1;
    end
endmodule

// File: rtl/slack_rx_chk.sv
// Property checker for slack_rx_link, attached through bind. It keeps a
// record of the last flow symbol sent, to check that stop and go alternate.
module slack_rx_chk
    import slack_pkg::*;
#(
    parameter int DEPTH = 80,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [8:0]       rx_sym,
    input logic             out_valid,
    input logic             out_ready,
    input logic             tx_req_valid,
    input logic [8:0]       tx_req_sym,
    input logic             tx_req_ready,
    input logic             tx_valid,
    input logic [8:0]       tx_sym,
    input logic             ovf_err,
    input logic [LVL_W-1:0] level
);
    logic last_was_stop;

    // Track the most recent flow symbol on the outgoing channel
    always_ff @(posedge clk) begin
        if (!rst_n)                              last_was_stop <= 1'b0;
        else if (tx_valid && tx_sym == STOP_SYM) last_was_stop <= 1'b1;
        else if (tx_valid && tx_sym == GO_SYM)   last_was_stop <= 1'b0;
    end

    // R4
    stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sym == STOP_SYM) |-> !last_was_stop);
    // R5
    go_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sym == GO_SYM) |-> last_was_stop);
    // R3
    flow_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && is_flow(rx_sym) && !(out_valid && out_ready))
        |=> level == $past(level));
    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    // R8
    ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !is_flow(rx_sym) && level == LVL_W'(DEPTH)) |=> ovf_err);
    // R6
    local_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_valid && tx_req_ready) |=> (tx_valid && tx_sym == $past(tx_req_sym)));
    // R7
    pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sym == STOP_SYM) |=> !tx_req_ready);
endmodule

bind slack_rx_link slack_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sym       (rx_sym),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .tx_req_valid (tx_req_valid),
    .tx_req_sym   (tx_req_sym),
    .tx_req_ready (tx_req_ready),
    .tx_valid     (tx_valid),
    .tx_sym       (tx_sym),
    .ovf_err      (ovf_err),
    .level        (fill_lvl)
);

// File: tb/sim_slack_rx_link.sv
module sim_slack_rx_link;
    localparam logic [8:0] STOP_S = 9'h1F1;
    localparam logic [8:0] GO_S   = 9'h1F2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, out_ready, tx_req_valid;
    logic [8:0] rx_sym, tx_req_sym;
    logic       out_valid, tx_req_ready, tx_valid, ovf_err;
    logic [8:0] out_sym, tx_sym;

    int checks = 0;
    int fails  = 0;
    int n_stop = 0;
    int n_go   = 0;
    int cyc    = 0;

    // Bit 9: symbol expected to be stored; bits 8:0: symbol sent
    localparam int NVEC = 10;
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 9'h012}, {1'b0, STOP_S}, {1'b1, 9'h0FF}, {1'b1, 9'h1A5},
        {1'b0, GO_S},   {1'b1, 9'h000}, {1'b0, STOP_S}, {1'b0, STOP_S},
        {1'b1, 9'h080}, {1'b0, GO_S}
    };

    always #2 clk = ~clk;

    slack_rx_link u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sym(rx_sym),
        .out_valid(out_valid), .out_sym(out_sym), .out_ready(out_ready),
        .tx_req_valid(tx_req_valid), .tx_req_sym(tx_req_sym),
        .tx_req_ready(tx_req_ready), .tx_valid(tx_valid), .tx_sym(tx_sym),
        .ovf_err(ovf_err)
    );

    // Count flow symbols leaving on the outgoing channel
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_sym == STOP_S) n_stop++;
        if (rst_n && tx_valid && tx_sym == GO_S)   n_go++;
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [8:0] s);
        rx_valid = 1'b1;
        rx_sym   = s;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic [8:0] exp, input string req);
        chk(out_valid && out_sym == exp, req, int'(out_sym), int'(exp));
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
    endtask

    initial begin
        logic [8:0] q[$];
        rst_n = 1'b0; rx_valid = 1'b0; rx_sym = '0; out_ready = 1'b0;
        tx_req_valid = 1'b0; tx_req_sym = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
        chk(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
        chk(!ovf_err, "R1 ovf_err", int'(ovf_err), 0);
        chk(tx_req_ready, "R1 tx_req_ready", int'(tx_req_ready), 1);

        // R2 R3 table of mixed symbols
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][8:0]);
            if (VEC[i][9]) q.push_back(VEC[i][8:0]);
            if (VEC[i][8:0] == STOP_S)
                chk(!tx_req_ready, "R7 paused by rx stop", int'(tx_req_ready), 0);
            if (VEC[i][8:0] == GO_S)
                chk(tx_req_ready, "R7 resumed by rx go", int'(tx_req_ready), 1);
        end
        while (q.size() > 0) pop_chk(q.pop_front(), "R2 order");
        chk(!out_valid, "R3 flow symbols not stored", int'(out_valid), 0);

        // R4 stop threshold
        for (int i = 0; i < 47; i++) push({1'b0, 8'(i)});
        chk(n_stop == 0 && !tx_valid, "R4 no stop below 48", n_stop, 0);
        push({1'b0, 8'd47});
        chk(!tx_req_ready, "R6 flow symbol blocks local", int'(tx_req_ready), 0);
        step();
        chk(tx_valid && tx_sym == STOP_S, "R4 stop at 48", int'(tx_sym), int'(STOP_S));
        for (int i = 48; i < 60; i++) push({1'b0, 8'(i)});
        chk(n_stop == 1, "R4 stop sent once", n_stop, 1);

        // R5 go threshold
        for (int i = 0; i < 27; i++) pop_chk({1'b0, 8'(i)}, "R2 drain order");
        step(); step();
        chk(n_go == 0, "R5 no go above 32", n_go, 0);
        pop_chk({1'b0, 8'd27}, "R2 drain order");
        step();
        chk(tx_valid && tx_sym == GO_S, "R5 go at 32", int'(tx_sym), int'(GO_S));
        for (int i = 28; i < 60; i++) pop_chk({1'b0, 8'(i)}, "R2 drain order");
        chk(n_go == 1, "R5 go sent once", n_go, 1);

        // R9 full capacity, R8 overflow
        for (int i = 0; i < 80; i++) push({1'b0, 8'(i)});
        chk(!ovf_err, "R9 80 held without error", int'(ovf_err), 0);
        push(9'h0AA);
        chk(ovf_err, "R8 overflow flagged", int'(ovf_err), 1);
        for (int i = 0; i < 80; i++) pop_chk({1'b0, 8'(i)}, "R8 R9 contents kept");
        chk(!out_valid, "R8 extra symbol dropped", int'(out_valid), 0);
        chk(ovf_err, "R8 error sticky", int'(ovf_err), 1);
        chk(n_stop == 2 && n_go == 2, "R4 R5 alternate", n_stop * 16 + n_go, 34);

        // R7 pause after current byte
        tx_req_valid = 1'b1; tx_req_sym = 9'h055;
        rx_valid = 1'b1; rx_sym = STOP_S;
        step();
        rx_valid = 1'b0;
        chk(tx_valid && tx_sym == 9'h055, "R7 current byte sent", int'(tx_sym), 9'h055);
        chk(!tx_req_ready, "R7 ready low", int'(tx_req_ready), 0);
        step();
        chk(!tx_valid, "R7 held while paused", int'(tx_valid), 0);
        push(GO_S);
        chk(tx_req_ready, "R7 ready after go", int'(tx_req_ready), 1);
        step();
        chk(tx_valid && tx_sym == 9'h055, "R6 local data sent", int'(tx_sym), 9'h055);
        tx_req_valid = 1'b0;
        step();
        chk(!tx_valid, "R10 idle channel", int'(tx_valid), 0);

        report();
        $finish;
    end
endmodule